// File: doc/BRIEF.md
# Byte-Serial AES-128 Output-Feedback Keystream Core

This core turns a 128-bit key and a 128-bit initialization vector into a sequence of 128-bit keystream words for a passive tag. The core runs AES-128 encryption in output-feedback fashion. The first word is the IV encrypted under the key. Every later word is the previous word encrypted again under the same key. The tag XORs each data block with the matching word. Because the same words come out on both sides, one encryption engine serves both ciphering and deciphering.

The datapath is sized for very low area. A single substitution unit handles everything that needs a substitution, one byte per clock. It is shared between the sixteen state bytes and the four bytes that the on-the-fly key schedule substitutes in each round. A controller walks every round through three phases. ST_KEYSUB takes 4 cycles and substitutes the rotated last key word. ST_STSUB takes 16 cycles and substitutes the state bytes in place; the row rotation is applied on the last of these cycles. ST_MIX takes 4 cycles and, for each column, computes the column mix, derives the next round-key word and adds that word in. The final round skips the column mix. Two further states sit around these phases: ST_IDLE, held after reset, and ST_HOLD, held after a word is ready. The transitions are:
- ST_IDLE to ST_KEYSUB on a start strobe.
- ST_KEYSUB to ST_STSUB after 4 cycles.
- ST_STSUB to ST_MIX after 16 cycles.
- ST_MIX to ST_KEYSUB after 4 cycles while rounds remain.
- ST_MIX to ST_HOLD after the tenth round.
- ST_HOLD to ST_KEYSUB on a start strobe (new key and IV) or on a next strobe (feedback).

Top module: `aes_ofb_keystream`

## Requirements
- R1: After reset, ks_valid_o is 0 and ks_o is all zeros.
- R2: A start strobe accepted in the idle or hold state makes the next keystream word equal to AES-128 encryption of iv_i under key_i. Both are sampled at the strobe edge. Byte 0 of every 128-bit value is bits [127:120], and bytes fill the AES state column by column.
- R3: A next strobe in the hold state makes the next word equal to AES-128 encryption of the current ks_o under the key of the last accepted start.
- R4: ks_valid_o rises exactly 240 clock cycles after the edge that accepts a start or next strobe. That is 10 rounds of 24 cycles each.
- R5: ks_valid_o is high for exactly one cycle per word. ks_o changes only in that cycle and is held until the next word completes.
- R6: A next strobe is ignored while a word is being computed and while idle after reset. An ignored strobe changes neither the timing nor the value of any later word, and no word appears.
- R7: A start strobe is ignored while a word is being computed. The word in progress completes with the original key and IV.
- R8: The substitution unit maps every byte value to the AES forward S-box value: the GF(2^8) inverse under polynomial 0x11B, followed by the affine transform with constant 0x63.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock, rising edge |
| rst_n | input | 1 | Asynchronous active-low reset |
| start_i | input | 1 | Load key and IV and begin the first block |
| next_i | input | 1 | Encrypt the current keystream word again |
| key_i | input | 128 | AES-128 key, sampled on an accepted start |
| iv_i | input | 128 | Initialization vector, sampled on an accepted start |
| ks_o | output | 128 | Most recent keystream word |
| ks_valid_o | output | 1 | One-cycle pulse when ks_o holds a new word |

## Verification
The core has no free size parameter. AES-128 fixes the block width, the key width and the round count as package constants, so the bench builds the only configuration there is. Because the substitution unit is small, the bench sweeps all 256 of its inputs exhaustively against a table it derives by brute-force inversion. Full blocks are compared with the published AES-128 example vectors and with a chain of three feedback words from a parallel reference model written in the bench. The cycle-exact latency is checked. So are strobes arriving in every phase: start and next during a run, and next before any start.

// File: rtl/aes_ks_pkg.sv
package aes_ks_pkg;
    localparam int BLK_W          = 128;
    localparam int BYTE_W         = 8;
    localparam int WORD_W         = 32;
    localparam int N_BYTES        = BLK_W / BYTE_W;
    localparam int N_WORDS        = BLK_W / WORD_W;
    localparam int BYTES_PER_WORD = WORD_W / BYTE_W;
    localparam int N_ROUNDS       = 10;
    localparam int CNT_W          = $clog2(N_BYTES);
    localparam int RND_W          = $clog2(N_ROUNDS + 1);

    typedef enum logic [2:0] {
        ST_IDLE,
        ST_KEYSUB,
        ST_STSUB,
        ST_MIX,
        ST_HOLD
    } phase_t;

    // multiply by x modulo x^8+x^4+x^3+x+1
    function automatic logic [7:0] gf_dbl(input logic [7:0] a);
        return {a[6:0], 1'b0} ^ (a[7] ? 8'h1b : 8'h00);
    endfunction

    function automatic logic [7:0] gf_mul(input logic [7:0] a, input logic [7:0] b);
        logic [7:0] acc;
        logic [7:0] x;
        acc = 8'h00;
        x   = a;
        for (int i = 0; i < 8; i++) begin
            if (b[i]) acc = acc ^ x;
            x = gf_dbl(x);
        end
        return acc;
    endfunction

    // a^254 by an addition chain; maps 0 to 0
    function automatic logic [7:0] gf_inv(input logic [7:0] a);
        logic [7:0] p2, p3, p12, p15, p240, p252;
        p2   = gf_mul(a, a);
        p3   = gf_mul(p2, a);
        p12  = gf_mul(gf_mul(p3, p3), gf_mul(p3, p3));
        p15  = gf_mul(p12, p3);
        p240 = gf_mul(p15, p15);
        p240 = gf_mul(p240, p240);
        p240 = gf_mul(p240, p240);
        p240 = gf_mul(p240, p240);
        p252 = gf_mul(p240, p12);
        return gf_mul(p252, p2);
    endfunction

    function automatic logic [7:0] sbox_fwd(input logic [7:0] a);
        logic [7:0] v;
        v = gf_inv(a);
        return v ^ {v[6:0], v[7]} ^ {v[5:0], v[7:6]} ^ {v[4:0], v[7:5]}
                 ^ {v[3:0], v[7:4]} ^ 8'h63;
    endfunction
endpackage

// File: rtl/aes_sbox_unit.sv
module aes_sbox_unit
    import aes_ks_pkg::*;
(
    input  logic [BYTE_W-1:0] a_i,
    output logic [BYTE_W-1:0] y_o
);
    always_comb begin
        y_o = sbox_fwd(a_i);
    end
endmodule

// File: rtl/aes_mixcol.sv
module aes_mixcol
    import aes_ks_pkg::*;
(
    input  logic [WORD_W-1:0] col_i,
    output logic [WORD_W-1:0] col_o
);
    logic [BYTE_W-1:0] b [BYTES_PER_WORD];
    logic [BYTE_W-1:0] d [BYTES_PER_WORD];

    generate
        for (genvar g = 0; g < BYTES_PER_WORD; g++) begin : g_split
            assign b[g] = col_i[WORD_W-1-BYTE_W*g -: BYTE_W];
            assign d[g] = gf_dbl(b[g]);
        end
    endgenerate

    // each output row: 2*own ^ 3*next ^ the remaining two
    generate
        for (genvar g = 0; g < BYTES_PER_WORD; g++) begin : g_row
            assign col_o[WORD_W-1-BYTE_W*g -: BYTE_W] =
                d[g] ^ d[(g+1)%4] ^ b[(g+1)%4] ^ b[(g+2)%4] ^ b[(g+3)%4];
        end
    endgenerate
endmodule

// File: rtl/aes_ofb_keystream.sv
module aes_ofb_keystream
    import aes_ks_pkg::*;
(
    input  logic             clk,
    input  logic             rst_n,
    input  logic             start_i,
    input  logic             next_i,
    input  logic [BLK_W-1:0] key_i,
    input  logic [BLK_W-1:0] iv_i,
    output logic [BLK_W-1:0] ks_o,
    output logic             ks_valid_o
);
    phase_t              ph_q, ph_d;
    logic [CNT_W-1:0]    cnt_q;
    logic [RND_W-1:0]    rnd_q;
    logic [BYTE_W-1:0]   rcon_q;
    logic [BLK_W-1:0]    st_q, rk_q, k0_q;
    logic [BLK_W-1:0]    st_nx, rk_nx, sub_st;
    logic [WORD_W-1:0]   tw_q;
    logic [BYTE_W-1:0]   sb_in, sb_out;
    logic [WORD_W-1:0]   col_sel, col_mix, kw_old, kw_left, kw_prev, kw_new;
    logic                final_rnd, last_word, last_byte, busy, launch, relaunch;
    logic [1:0]          wsel, ksel;

    assign wsel      = cnt_q[1:0];
    assign ksel      = cnt_q[1:0] + 2'd1;
    assign final_rnd = (rnd_q == RND_W'(N_ROUNDS));
    assign last_word = (cnt_q == CNT_W'(BYTES_PER_WORD - 1));
    assign last_byte = (cnt_q == CNT_W'(N_BYTES - 1));
    assign busy      = (ph_q == ST_KEYSUB) || (ph_q == ST_STSUB) || (ph_q == ST_MIX);
    assign launch    = start_i && ((ph_q == ST_IDLE) || (ph_q == ST_HOLD));
    assign relaunch  = next_i && !start_i && (ph_q == ST_HOLD);

    // shared substitution unit
    always_comb begin
        unique case (ph_q)
            ST_KEYSUB: sb_in = rk_q[BLK_W-1-BYTE_W*(3*BYTES_PER_WORD+int'(ksel)) -: BYTE_W];
            ST_STSUB:  sb_in = st_q[BLK_W-1-BYTE_W*int'(cnt_q) -: BYTE_W];
            default:   sb_in = '0;
        endcase
    end

    aes_sbox_unit u_sbox (
        .a_i (sb_in),
        .y_o (sb_out)
    );

    // column path and on-the-fly key word
    assign col_sel = st_q[BLK_W-1-WORD_W*int'(wsel) -: WORD_W];
    assign kw_old  = rk_q[BLK_W-1-WORD_W*int'(wsel) -: WORD_W];
    assign kw_left = rk_q[BLK_W-1-WORD_W*int'(wsel + 2'd3) -: WORD_W];
    assign kw_prev = (wsel == 2'd0) ? (tw_q ^ {rcon_q, 24'h000000}) : kw_left;
    assign kw_new  = kw_old ^ kw_prev;

    aes_mixcol u_mix (
        .col_i (col_sel),
        .col_o (col_mix)
    );

    // next state/key contents for the active phase
    always_comb begin
        st_nx  = st_q;
        rk_nx  = rk_q;
        sub_st = st_q;
        sub_st[BLK_W-1-BYTE_W*int'(cnt_q) -: BYTE_W] = sb_out;
        unique case (ph_q)
            ST_STSUB: begin
                if (last_byte) begin
                    for (int c = 0; c < N_WORDS; c++) begin
                        for (int r = 0; r < BYTES_PER_WORD; r++) begin
                            st_nx[BLK_W-1-BYTE_W*(4*c+r) -: BYTE_W] =
                                sub_st[BLK_W-1-BYTE_W*(4*((c+r)%4)+r) -: BYTE_W];
                        end
                    end
                end else begin
                    st_nx = sub_st;
                end
            end
            ST_MIX: begin
                st_nx[BLK_W-1-WORD_W*int'(wsel) -: WORD_W] =
                    (final_rnd ? col_sel : col_mix) ^ kw_new;
                rk_nx[BLK_W-1-WORD_W*int'(wsel) -: WORD_W] = kw_new;
            end
            default: ;
        endcase
    end

    // phase sequencing
    always_comb begin
        ph_d = ph_q;
        unique case (ph_q)
            ST_IDLE:   if (start_i) ph_d = ST_KEYSUB;
            ST_KEYSUB: if (last_word) ph_d = ST_STSUB;
            ST_STSUB:  if (last_byte) ph_d = ST_MIX;
            ST_MIX:    if (last_word) ph_d = final_rnd ? ST_HOLD : ST_KEYSUB;
            ST_HOLD:   if (start_i || next_i) ph_d = ST_KEYSUB;
            default:   ph_d = ST_IDLE;
        endcase
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) ph_q <= ST_IDLE;
        else        ph_q <= ph_d;
    end

    // datapath and outputs
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            cnt_q      <= '0;
            rnd_q      <= '0;
            rcon_q     <= 8'h01;
            st_q       <= '0;
            rk_q       <= '0;
            k0_q       <= '0;
            tw_q       <= '0;
            ks_o       <= '0;
            ks_valid_o <= 1'b0;
        end else begin
            ks_valid_o <= 1'b0;
            if (ph_d != ph_q || !busy) cnt_q <= '0;
            else                        cnt_q <= cnt_q + 1'b1;

            if (launch) begin
                st_q   <= iv_i ^ key_i;
                rk_q   <= key_i;
                k0_q   <= key_i;
                rnd_q  <= RND_W'(1);
                rcon_q <= 8'h01;
            end else if (relaunch) begin
                st_q   <= st_q ^ k0_q;
                rk_q   <= k0_q;
                rnd_q  <= RND_W'(1);
                rcon_q <= 8'h01;
            end else begin
                st_q <= st_nx;
                rk_q <= rk_nx;
                if (ph_q == ST_KEYSUB)
                    tw_q[WORD_W-1-BYTE_W*int'(wsel) -: BYTE_W] <= sb_out;
                if (ph_q == ST_MIX && last_word) begin
                    if (final_rnd) begin
                        ks_o       <= st_nx;
                        ks_valid_o <= 1'b1;
                    end else begin
                        rnd_q  <= rnd_q + 1'b1;
                        rcon_q <= gf_dbl(rcon_q);
                    end
                end
            end
        end
    end

    // ---------------- assertions ----------------
    p_valid_single_r5: assert property (@(posedge clk) disable iff (!rst_n)
        ks_valid_o |=> !ks_valid_o)
        else $error("keystream valid longer than one cycle");

    p_ks_held_r5: assert property (@(posedge clk) disable iff (!rst_n)
        !ks_valid_o |-> $stable(ks_o))
        else $error("keystream changed without valid");

    p_valid_in_hold_r4: assert property (@(posedge clk) disable iff (!rst_n)
        ks_valid_o |-> (ph_q == ST_HOLD))
        else $error("valid outside hold phase");

    p_round_bound_r4: assert property (@(posedge clk) disable iff (!rst_n)
        busy |-> (rnd_q >= RND_W'(1) && rnd_q <= RND_W'(N_ROUNDS)))
        else $error("round index out of range");

    p_word_phase_len_r4: assert property (@(posedge clk) disable iff (!rst_n)
        (ph_q == ST_KEYSUB || ph_q == ST_MIX) |-> (cnt_q < CNT_W'(BYTES_PER_WORD)))
        else $error("word phase overran");

    p_key_kept_r7: assert property (@(posedge clk) disable iff (!rst_n)
        busy |=> $stable(k0_q))
        else $error("base key reloaded during a run");

    p_no_word_when_idle_r6: assert property (@(posedge clk) disable iff (!rst_n)
        (ph_q == ST_IDLE) |=> !ks_valid_o)
        else $error("word produced from idle");
endmodule

// File: tb/tb_aes_ofb_keystream.sv
module tb_aes_ofb_keystream;
    logic         clk = 1'b0;
    logic         rst_n = 1'b0;
    logic         start_i = 1'b0;
    logic         next_i = 1'b0;
    logic [127:0] key_i = '0;
    logic [127:0] iv_i = '0;
    logic [127:0] ks_o;
    logic         ks_valid_o;
    logic [7:0]   sb_probe = '0;
    logic [7:0]   sb_res;

    int n_chk  = 0;
    int n_fail = 0;
    int wd     = 0;

    logic [7:0] sbt [256];

    always #5 clk = ~clk;

    aes_ofb_keystream dut (
        .clk, .rst_n, .start_i, .next_i, .key_i, .iv_i, .ks_o, .ks_valid_o
    );

    aes_sbox_unit u_sb (.a_i(sb_probe), .y_o(sb_res));

    always @(posedge clk) begin
        wd++;
        if (wd > 150000) begin
            n_chk++;
            n_fail++;
            $display("FAIL watchdog expired act=%0d exp<150000", wd);
            $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
            $finish;
        end
    end

    function automatic logic [7:0] rmul(input logic [7:0] a, input logic [7:0] b);
        logic [15:0] p;
        p = '0;
        for (int i = 0; i < 8; i++) if (b[i]) p = p ^ (16'(a) << i);
        for (int i = 15; i >= 8; i--) if (p[i]) p = p ^ (16'h011b << (i - 8));
        return p[7:0];
    endfunction

    function automatic logic [31:0] rsubw(input logic [31:0] w);
        return {sbt[w[31:24]], sbt[w[23:16]], sbt[w[15:8]], sbt[w[7:0]]};
    endfunction

    function automatic logic [127:0] ref_aes(input logic [127:0] k, input logic [127:0] pt);
        logic [31:0]  w [44];
        logic [7:0]   s [16];
        logic [7:0]   t [16];
        logic [7:0]   rc, a0, a1, a2, a3;
        logic [31:0]  tmp;
        logic [127:0] out;
        for (int i = 0; i < 4; i++) w[i] = k[127-32*i -: 32];
        rc = 8'h01;
        for (int i = 4; i < 44; i++) begin
            tmp = w[i-1];
            if (i % 4 == 0) begin
                tmp = rsubw({tmp[23:0], tmp[31:24]}) ^ {rc, 24'h0};
                rc  = rmul(rc, 8'h02);
            end
            w[i] = w[i-4] ^ tmp;
        end
        for (int b = 0; b < 16; b++) s[b] = pt[127-8*b -: 8];
        for (int c = 0; c < 4; c++)
            for (int r = 0; r < 4; r++) s[4*c+r] = s[4*c+r] ^ w[c][31-8*r -: 8];
        for (int rd = 1; rd <= 10; rd++) begin
            for (int b = 0; b < 16; b++) s[b] = sbt[s[b]];
            for (int c = 0; c < 4; c++)
                for (int r = 0; r < 4; r++) t[4*c+r] = s[4*((c+r)%4)+r];
            if (rd < 10) begin
                for (int c = 0; c < 4; c++) begin
                    a0 = t[4*c]; a1 = t[4*c+1]; a2 = t[4*c+2]; a3 = t[4*c+3];
                    t[4*c]   = rmul(a0, 8'h02) ^ rmul(a1, 8'h03) ^ a2 ^ a3;
                    t[4*c+1] = a0 ^ rmul(a1, 8'h02) ^ rmul(a2, 8'h03) ^ a3;
                    t[4*c+2] = a0 ^ a1 ^ rmul(a2, 8'h02) ^ rmul(a3, 8'h03);
                    t[4*c+3] = rmul(a0, 8'h03) ^ a1 ^ a2 ^ rmul(a3, 8'h02);
                end
            end
            for (int c = 0; c < 4; c++)
                for (int r = 0; r < 4; r++) s[4*c+r] = t[4*c+r] ^ w[4*rd+c][31-8*r -: 8];
        end
        for (int b = 0; b < 16; b++) out[127-8*b -: 8] = s[b];
        return out;
    endfunction

    task automatic chk(input string req, input logic [127:0] act, input logic [127:0] exp);
        n_chk++;
        if (act !== exp) begin
            n_fail++;
            $display("FAIL %s act=%h exp=%h", req, act, exp);
        end
    endtask

    // strobe one input for one edge; returns at the negedge after it
    task automatic pulse(input bit is_start);
        @(negedge clk);
        if (is_start) start_i = 1'b1; else next_i = 1'b1;
        @(negedge clk);
        start_i = 1'b0;
        next_i  = 1'b0;
    endtask

    // count negedges until valid; also checks the one-cycle pulse
    task automatic wait_word(input string req, output int cyc);
        cyc = 0;
        while (!ks_valid_o && cyc < 1000) begin
            @(negedge clk);
            cyc++;
        end
        chk({req, " latency R4"}, 128'(cyc), 128'd240);
        @(negedge clk);
        chk("valid single pulse R5", 128'(ks_valid_o), 128'd0);
    endtask

    initial begin
        logic [127:0] kA, ivA, kB, ivB, e1, e2, e3, held;
        int cyc, seen;
        for (int x = 0; x < 256; x++) begin
            logic [7:0] inv, v;
            inv = 8'h00;
            for (int y = 1; y < 256; y++) if (rmul(8'(x), 8'(y)) == 8'h01) inv = 8'(y);
            v = inv;
            sbt[x] = v ^ {v[6:0], v[7]} ^ {v[5:0], v[7:6]} ^ {v[4:0], v[7:5]}
                       ^ {v[3:0], v[7:4]} ^ 8'h63;
        end

        // R8 exhaustive substitution sweep
        for (int x = 0; x < 256; x++) begin
            sb_probe = 8'(x);
            #1;
            chk("sbox R8", 128'(sb_res), 128'(sbt[x]));
        end
        chk("sbox anchor R8", 128'(sbt[8'h53]), 128'h00ed);

        repeat (3) @(negedge clk);
        chk("reset valid R1", 128'(ks_valid_o), 128'd0);
        chk("reset ks R1", ks_o, 128'd0);
        rst_n = 1'b1;

        // R6 next before any start is ignored
        pulse(1'b0);
        seen = 0;
        for (int i = 0; i < 300; i++) begin
            @(negedge clk);
            if (ks_valid_o) seen++;
        end
        chk("idle next no word R6", 128'(seen), 128'd0);
        chk("idle next ks unchanged R6", ks_o, 128'd0);

        // R2 published example vector
        key_i = 128'h000102030405060708090a0b0c0d0e0f;
        iv_i  = 128'h00112233445566778899aabbccddeeff;
        pulse(1'b1);
        wait_word("fips", cyc);
        chk("fips example R2", ks_o, 128'h69c4e0d86a7b0430d8cdb78070b4c55a);

        // R2 second example from hold; start accepted in hold
        key_i = 128'h2b7e151628aed2a6abf7158809cf4f3c;
        iv_i  = 128'h3243f6a8885a308d313198a2e0370734;
        pulse(1'b1);
        wait_word("example2", cyc);
        chk("second example R2", ks_o, 128'h3925841d02dc09fbdc118597196a0b32);

        // R3 three-word feedback chain, with strobes during a run (R6, R7)
        kA  = 128'h8e73b0f7da0e6452c810f32b809079e5;
        ivA = 128'hf69f2445df4f9b17ad2b417be66c3710;
        kB  = 128'hffeeddccbbaa99887766554433221100;
        ivB = 128'h0123456789abcdeffedcba9876543210;
        e1 = ref_aes(kA, ivA);
        e2 = ref_aes(kA, e1);
        e3 = ref_aes(kA, e2);
        key_i = kA;
        iv_i  = ivA;
        pulse(1'b1);
        cyc = 0;
        seen = 0;
        for (int i = 1; i <= 400; i++) begin
            @(negedge clk);
            next_i  = (i == 30 || i == 200);
            start_i = (i == 100);
            if (i == 100) begin key_i = kB; iv_i = ivB; end
            if (ks_valid_o && cyc == 0) cyc = i;
            if (ks_valid_o) seen++;
            if (i > cyc + 2 && cyc != 0) break;
        end
        next_i = 1'b0;
        start_i = 1'b0;
        chk("busy strobes keep latency R6", 128'(cyc), 128'd240);
        chk("busy start keeps key R7", ks_o, e1);
        chk("one word only R6", 128'(seen), 128'd1);

        // R5 word held while nothing is strobed
        held = ks_o;
        seen = 0;
        for (int i = 0; i < 300; i++) begin
            @(negedge clk);
            if (ks_valid_o) seen++;
        end
        chk("no spurious word R5", 128'(seen), 128'd0);
        chk("word held R5", ks_o, held);

        pulse(1'b0);
        wait_word("feedback2", cyc);
        chk("feedback word 2 R3", ks_o, e2);
        pulse(1'b0);
        wait_word("feedback3", cyc);
        chk("feedback word 3 R3", ks_o, e3);

        $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
        $finish;
    end
endmodule